// File: doc/BRIEF.md
# Byte-Wide GPIO Port Register Block

This block is one eight-pin general-purpose I/O port reached through three byte registers on a small synchronous bus. One register sets which pins drive (a 1 makes the pin an output). One holds the levels the port drives. The third register behaves differently on reads and writes. A read returns the synchronized levels seen at the pins. A write flips the driven level of every pin whose data bit is 1, so software can toggle any set of pins in a single access.

Whenever a bus write changes the driven level of a pin that is set as an output, the block emits a one-cycle change strobe for that pin, together with the new level. Reads are registered: the data appears in the cycle after the request. Apart from its registers the block has no control state. The bus access decoded in each cycle is one of three named kinds: idle, read or write. No sequence is kept between accesses, so there are no state transitions to name.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is low and in the first cycle after it, the direction register, the output latch, `pin_oe`, `pin_out`, `bus_rdata`, `chg_strobe` and `chg_level` are all zero.
- R2: A read (`bus_sel`=1, `bus_we`=0) places its data on `bus_rdata` in the next cycle. Offset 0x1 returns the direction register and offset 0x2 returns the output latch.
- R3: A write to offset 0x1 stores the byte as the direction register, and `pin_oe` equals the direction register from the next cycle on.
- R4: A write to offset 0x2 stores the byte in the output latch, and `pin_out` equals the latch from the next cycle on.
- R5: A write to offset 0x0 stores nothing of its own. It replaces the latch with the latch XOR the written byte, so each 1 bit inverts that pin's driven level.
- R6: When a write to offset 0x0 or 0x2 changes latch bit i while direction bit i is 1, `chg_strobe[i]` is high for exactly one cycle. That cycle is the one after the cycle in which `pin_out` first shows the new value. In the same cycle `chg_level[i]` carries the new level.
- R7: Latch bits whose direction bit is 0, and bits that a write leaves unchanged, raise no strobe, and their `chg_level` bit stays 0.
- R8: A read of offset 0x0 returns `pin_in` as it was sampled two rising edges before the edge that accepts the read.
- R9: A write to an offset of 0x3 or above changes no register, and a read of such an offset returns zero.
- R10: `bus_rdata` is zero in every cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle after the read |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Driven pin levels (output latch) |
| pin_oe | output | 8 | Per-pin output enable (direction register) |
| chg_strobe | output | 8 | One-cycle per-pin change pulse |
| chg_level | output | 8 | New level of each strobed pin |

## Verification
The bench goes after the toggle path. A design that stored the toggle byte, or that gated the toggle by direction, would show the wrong `pin_out` after a write to offset 0x0. It also checks the strobe window. Strobes for input pins, strobes on rewriting an unchanged value, or pulses held for two cycles would all miscompare against the model. Reads of the pin register pin down the two-edge synchronizer latency: a design with one stage or three stages returns the neighbouring sample. Writes and reads at offsets 0x3 to 0x7 catch any decode that aliases the upper offsets onto the register window.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_PIN,
        SEL_DIR,
        SEL_LAT,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        acc,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            lat_q <= '0;
        end else if (acc == ACC_WRITE) begin
            unique case (sel)
                SEL_PIN:  lat_q <= lat_q ^ wdata;
                SEL_DIR:  dir_q <= wdata;
                SEL_LAT:  lat_q <= wdata;
                SEL_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] strobe,
    output logic [WIDTH-1:0] level
);
    logic [WIDTH-1:0] lat_prev_q;
    logic [WIDTH-1:0] hit;

    assign hit = dir_q & (lat_q ^ lat_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_prev_q <= '0;
            strobe     <= '0;
            level      <= '0;
        end else begin
            lat_prev_q <= lat_q;
            strobe     <= hit;
            level      <= lat_q & hit;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  chg_strobe,
    output logic [WIDTH-1:0]  chg_level
);
    localparam logic [ADDR_W-1:0] OFS_PIN = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_LAT = ADDR_W'(2);

    acc_kind_e        acc;
    reg_sel_e         sel;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] rdata_q;

    always_comb begin
        if (!bus_sel)    acc = ACC_IDLE;
        else if (bus_we) acc = ACC_WRITE;
        else             acc = ACC_READ;
    end

    always_comb begin
        if (bus_addr == OFS_PIN)      sel = SEL_PIN;
        else if (bus_addr == OFS_DIR) sel = SEL_DIR;
        else if (bus_addr == OFS_LAT) sel = SEL_LAT;
        else                          sel = SEL_NONE;
    end

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_reg_file #(.WIDTH(WIDTH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .sel   (sel),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpio_chg_detect #(.WIDTH(WIDTH)) u_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_q  (dir_q),
        .lat_q  (lat_q),
        .strobe (chg_strobe),
        .level  (chg_level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (acc == ACC_READ) begin
            unique case (sel)
                SEL_PIN:  rdata_q <= pin_sync;
                SEL_DIR:  rdata_q <= dir_q;
                SEL_LAT:  rdata_q <= lat_q;
                SEL_NONE: rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = lat_q;
    assign pin_oe    = dir_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  chg_strobe
);
    logic wr_any, rd_any;
    assign wr_any = bus_sel && bus_we;
    assign rd_any = bus_sel && !bus_we;

    AST_DIR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(1)) |=> (pin_oe == $past(bus_wdata))); // R3

    AST_LATCH_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(2)) |=> (pin_out == $past(bus_wdata))); // R4

    AST_TOGGLE_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(0)) |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata)))); // R5

    AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(2)) |=> ##1
        (chg_strobe == ($past(pin_oe, 2) & ($past(pin_out, 1) ^ $past(pin_out, 2))))); // R6

    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg_strobe & ~($past(pin_oe) & ($past(pin_out) ^ $past(pin_out, 2)))) == '0)); // R7

    AST_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == ADDR_W'(1)) |=> (bus_rdata == $past(pin_oe))); // R2

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr >= ADDR_W'(3)) |=> (bus_rdata == '0)); // R9

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr >= ADDR_W'(3)) |=> ($stable(pin_out) && $stable(pin_oe))); // R9

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> (bus_rdata == '0)); // R10
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .chg_strobe (chg_strobe)
);

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int AW = 4;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_out, pin_oe, chg_strobe, chg_level;

    gpio_port_regs #(.WIDTH(W), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .chg_strobe(chg_strobe), .chg_level(chg_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    armed = 0;
    string cur_req = "R1";

    // behavioural reference state
    int       m_dir = 0, m_lat = 0, m_rd = 0, m_str = 0, m_lvl = 0, pend = 0;
    int       pin_hist[$] = '{0, 0};

    always @(posedge clk) begin
        int rd_val, new_lat, a;
        a = int'(bus_addr);
        if (!rst_n) begin
            m_dir = 0; m_lat = 0; m_rd = 0; m_str = 0; m_lvl = 0; pend = 0;
            pin_hist = '{0, 0};
        end else begin
            m_str = pend;
            m_lvl = m_lat & pend;
            rd_val = 0;
            if (a == 0) rd_val = pin_hist[0];
            else if (a == 1) rd_val = m_dir;
            else if (a == 2) rd_val = m_lat;
            m_rd = (bus_sel && !bus_we) ? rd_val : 0;
            new_lat = m_lat;
            if (bus_sel && bus_we) begin
                if (a == 0) new_lat = m_lat ^ int'(bus_wdata);
                else if (a == 2) new_lat = int'(bus_wdata);
                else if (a == 1) m_dir = int'(bus_wdata);
            end
            pend = m_dir & (new_lat ^ m_lat);
            m_lat = new_lat;
            void'(pin_hist.pop_front());
            pin_hist.push_back(int'(pin_in));
        end
        armed = 1;
    end

    task automatic cmp(string what, string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            cmp("pin_oe",     (cur_req == "R1") ? "R1" : "R3", int'(pin_oe), m_dir);
            cmp("pin_out",    cur_req, int'(pin_out), m_lat);
            cmp("bus_rdata",  cur_req, int'(bus_rdata), m_rd);
            cmp("chg_strobe", cur_req, int'(chg_strobe), m_str);
            cmp("chg_level",  cur_req, int'(chg_level), m_lvl);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic access(input bit sel, input bit we, input int addr, input int data);
        bus_sel   = sel;
        bus_we    = we;
        bus_addr  = AW'(addr);
        bus_wdata = W'(data);
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data); access(1, 1, addr, data); endtask
    task automatic rd(input int addr);                 access(1, 0, addr, 0);    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) access(0, 0, 0, 0);
    endtask

    initial begin
        logic [31:0] lfsr;
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R4: latch store with all pins as inputs; R7 no strobes
        cur_req = "R4";
        wr(2, 8'hA5); idle(3);
        cur_req = "R7";
        wr(2, 8'hA5); idle(3);
        // R3: direction register
        cur_req = "R3";
        wr(1, 8'hFF); idle(2);
        // R6: latch change on outputs -> strobes
        cur_req = "R6";
        wr(2, 8'h5A); idle(3);
        wr(2, 8'h00); wr(2, 8'hFF); idle(3);
        // R5: toggle through pin register
        cur_req = "R5";
        wr(0, 8'h0F); idle(3);
        wr(0, 8'h0F); wr(0, 8'hF0); idle(3);
        // R7: partial direction, only output bits strobe
        cur_req = "R7";
        wr(1, 8'h0F); wr(2, 8'h33); idle(3);
        wr(0, 8'hFF); idle(3);
        // R2: register read-back and R10 idle data
        cur_req = "R2";
        rd(1); rd(2); idle(1);
        cur_req = "R10";
        rd(2); idle(3);
        // R9: unmapped offsets
        cur_req = "R9";
        wr(3, 8'hFF); wr(7, 8'h00); wr(15, 8'h55); idle(2);
        rd(3); rd(8); rd(15); idle(2);
        // R8: pin register synchronizer latency
        cur_req = "R8";
        for (int i = 0; i < 12; i++) begin
            pin_in = W'((i * 37 + 5) & 8'hFF);
            rd(0);
        end
        idle(3);
        // R6: mixed random traffic
        cur_req = "R6";
        lfsr = 32'h1BADF00D;
        for (int i = 0; i < 300; i++) begin
            lfsr   = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pin_in = lfsr[15:8];
            case (lfsr[1:0])
                2'd0: idle(1);
                2'd1, 2'd3: wr(int'(lfsr[4:2]), int'(lfsr[23:16]));
                default: rd(int'(lfsr[4:2]));
            endcase
        end
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule